// File: doc/BRIEF.md
# Request/Acknowledge Clock-Domain Crossing Link

This block carries one multi-bit word at a time from a source clock domain to a destination clock domain whose clock has no fixed relation to the source clock. The source side accepts a word through a valid/ready pair and parks it in a source-domain holding register. It then signals a request that crosses into the destination through a chain of synchronizing flops. The destination copies the parked word into its own register and emits a one-cycle valid strobe. It then answers with an acknowledge that crosses back through a second synchronizer chain. Only once that answer is seen does the source take another word.

A parameter picks the signaling style. In the toggle style, every word costs one level change on the request and one on the acknowledge. In the return-to-zero style, the request and acknowledge each rise and then fall for every word. In both styles the round trip is a bounded number of clock periods on each side, and that bound sets the highest word rate. Each domain has its own synchronous, active-high reset. The two resets may be released in either order.

Top module: `hs_cdc_link`

## Requirements
- R1: While either reset is held and after both are released, with no valid offered, `src_ready` is 1, `dst_valid` is 0 and `dst_data` is 0. Releasing the two resets at different times produces no `dst_valid` pulse.
- R2: From the source edge that accepts a word until the source is ready again, the parked payload that the destination samples does not change.
- R3: A word is accepted on a source clock edge where `src_valid` and `src_ready` are both 1. `src_ready` is 0 from the next source cycle until the handshake completes. A `src_valid` offered while `src_ready` is 0 is ignored and never reaches `dst_data`.
- R4: Every accepted word shows up on `dst_data` exactly once, in acceptance order, with `dst_valid` high for exactly one destination cycle. This also holds when consecutive words are equal and when the source offers words back to back.
- R5: Between transfers, `dst_data` keeps the last delivered word.
- R6: In toggle mode (PROTO = HS_TWO_PHASE), each word costs one request transition and one acknowledge transition. With back-to-back offers, the time between successive acceptances is at least 2·Tsrc + 2·Tdst and at most 3·Tsrc + 3·Tdst.
- R7: In return-to-zero mode (PROTO = HS_FOUR_PHASE), each word costs request rise, acknowledge rise, request fall and acknowledge fall, in that order. The source lowers its request only after seeing the acknowledge high. With back-to-back offers, the time between successive acceptances is at least 4·Tsrc + 4·Tdst and at most 6·Tsrc + 6·Tdst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source-domain clock |
| src_rst | input | 1 | Source-domain synchronous reset, active high |
| src_valid | input | 1 | Source offers a word |
| src_data | input | DATA_W | Offered word |
| src_ready | output | 1 | Link can accept a word this source cycle |
| dst_clk | input | 1 | Destination-domain clock |
| dst_rst | input | 1 | Destination-domain synchronous reset, active high |
| dst_valid | output | 1 | One-cycle strobe marking a newly delivered word |
| dst_data | output | DATA_W | Last delivered word |

## Verification
The bench drives a 27 MHz source against a 200 MHz destination in both signaling modes. It sends a word list that includes repeated equal words, which would vanish if the destination keyed on data changes instead of request transitions. It measures the spacing of back-to-back acceptances: a link that skipped a synchronizer stage, or reopened `ready` before the acknowledge, breaks the lower bound, and an extra pipeline stage breaks the upper one. It offers a word while the link is busy and checks that the word never appears, which catches a `ready` that reopens early or a holding register that loads while busy. It also releases the two resets at different times and checks that no strobe leaks out, which a mismatched reset value on the request or acknowledge would cause.

// File: rtl/hs_cdc_pkg.sv
`timescale 1ns/100ps
package hs_cdc_pkg;

    typedef enum logic {
        HS_TWO_PHASE  = 1'b0,
        HS_FOUR_PHASE = 1'b1
    } hs_proto_e;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_WAIT = 2'd1,
        SRC_DROP = 2'd2
    } src_state_e;

    typedef enum logic {
        DST_IDLE  = 1'b0,
        DST_ACKED = 1'b1
    } dst_state_e;

    // Request level driven when a new word is taken.
    function automatic logic hs_req_on_take(hs_proto_e proto, logic cur);
        return (proto == HS_FOUR_PHASE) ? 1'b1 : ~cur;
    endfunction

    // Destination sees a new request.
    function automatic logic hs_new_req(hs_proto_e proto, logic req_s,
                                        logic ack_cur, dst_state_e st);
        if (proto == HS_FOUR_PHASE)
            return req_s && (st == DST_IDLE);
        return req_s != ack_cur;
    endfunction

endpackage

// File: rtl/hs_sync.sv
`timescale 1ns/100ps
module hs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_src_ctrl.sv
`timescale 1ns/100ps
module hs_src_ctrl
    import hs_cdc_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter hs_proto_e   PROTO  = HS_TWO_PHASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              ack_s,
    output logic              req,
    output logic [DATA_W-1:0] hold
);
    localparam bit RZ = (PROTO == HS_FOUR_PHASE);

    src_state_e state;
    logic       req_q;
    logic       done;
    logic       take;

    always_comb begin
        done = 1'b0;
        unique case (state)
            SRC_WAIT: done = !RZ && (ack_s == req_q);
            SRC_DROP: done = RZ && !ack_s;
            default:  done = 1'b0;
        endcase
    end

    assign in_ready = (state == SRC_IDLE) || done;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SRC_IDLE;
            req_q <= 1'b0;
            hold  <= '0;
        end else if (take) begin
            hold  <= in_data;
            req_q <= hs_req_on_take(PROTO, req_q);
            state <= SRC_WAIT;
        end else begin
            unique case (state)
                SRC_WAIT: begin
                    if (RZ && ack_s) begin
                        req_q <= 1'b0;
                        state <= SRC_DROP;
                    end else if (!RZ && (ack_s == req_q)) begin
                        state <= SRC_IDLE;
                    end
                end
                SRC_DROP: if (!ack_s) state <= SRC_IDLE;
                default:  state <= SRC_IDLE;
            endcase
        end
    end

    assign req = req_q;

    // R2: parked payload frozen while the link is busy
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && $past(!in_ready)) |-> $stable(hold));

    // R3: a taken word closes ready on the next cycle
    a_r3_busy_after_take: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    generate
        if (RZ) begin : g_rz_chk
            // R7: request falls only after acknowledge was seen high
            a_r7_fall_after_ack: assert property (@(posedge clk) disable iff (rst)
                $fell(req_q) |-> $past(ack_s));
        end else begin : g_tg_chk
            // R6: request moves only on an accepted word
            a_r6_req_moves_on_take: assert property (@(posedge clk) disable iff (rst)
                (req_q != $past(req_q)) |-> $past(in_valid && in_ready));
        end
    endgenerate
endmodule

// File: rtl/hs_dst_ctrl.sv
`timescale 1ns/100ps
module hs_dst_ctrl
    import hs_cdc_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter hs_proto_e   PROTO  = HS_TWO_PHASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_s,
    input  logic [DATA_W-1:0] hold,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              ack
);
    localparam bit RZ = (PROTO == HS_FOUR_PHASE);

    dst_state_e state;
    logic       ack_q;
    logic       fresh;
    logic       release_rq;

    assign fresh      = hs_new_req(PROTO, req_s, ack_q, state);
    assign release_rq = RZ && (state == DST_ACKED) && !req_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= DST_IDLE;
            ack_q     <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (fresh) begin
                out_data  <= hold;
                out_valid <= 1'b1;
                if (RZ) begin
                    ack_q <= 1'b1;
                    state <= DST_ACKED;
                end else begin
                    ack_q <= req_s;
                end
            end else if (release_rq) begin
                ack_q <= 1'b0;
                state <= DST_IDLE;
            end
        end
    end

    assign ack = ack_q;

    // R4: delivery strobe lasts one destination cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R5: delivered word kept between strobes
    a_r5_data_held: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    // R4: acknowledge moves up only together with a delivery
    a_r4_ack_with_delivery: assert property (@(posedge clk) disable iff (rst)
        (ack_q && !$past(ack_q)) |-> out_valid);
endmodule

// File: rtl/hs_cdc_link.sv
`timescale 1ns/100ps
module hs_cdc_link
    import hs_cdc_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter hs_proto_e   PROTO       = HS_TWO_PHASE
) (
    input  logic              src_clk,
    input  logic              src_rst,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    input  logic              dst_clk,
    input  logic              dst_rst,
    output logic              dst_valid,
    output logic [DATA_W-1:0] dst_data
);
    logic              req_raw;
    logic              req_dst;
    logic              ack_raw;
    logic              ack_src;
    logic [DATA_W-1:0] parked;

    hs_src_ctrl #(.DATA_W(DATA_W), .PROTO(PROTO)) u_src (
        .clk      (src_clk),
        .rst      (src_rst),
        .in_valid (src_valid),
        .in_data  (src_data),
        .in_ready (src_ready),
        .ack_s    (ack_src),
        .req      (req_raw),
        .hold     (parked)
    );

    hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (dst_clk),
        .rst (dst_rst),
        .d   (req_raw),
        .q   (req_dst)
    );

    hs_dst_ctrl #(.DATA_W(DATA_W), .PROTO(PROTO)) u_dst (
        .clk       (dst_clk),
        .rst       (dst_rst),
        .req_s     (req_dst),
        .hold      (parked),
        .out_valid (dst_valid),
        .out_data  (dst_data),
        .ack       (ack_raw)
    );

    hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (src_clk),
        .rst (src_rst),
        .d   (ack_raw),
        .q   (ack_src)
    );
endmodule

// File: tb/hs_cdc_link_tb.sv
`timescale 1ns/100ps
module hs_cdc_link_tb;
    import hs_cdc_pkg::*;

    localparam real TS = 37.0;   // source period, about 27 MHz
    localparam real TD = 5.0;    // destination period, 200 MHz
    localparam int  W  = 16;
    localparam int  NW = 10;
    localparam logic [W-1:0] WORDS [0:NW-1] = '{
        16'h0001, 16'hFFFF, 16'h0000, 16'hA5A5, 16'hA5A5,
        16'h5A5A, 16'h8000, 16'h8000, 16'h7FFE, 16'h3C3C
    };

    logic sclk, dclk;
    logic         s_rst   [2];
    logic         d_rst   [2];
    logic         s_valid [2];
    logic [W-1:0] s_data  [2];
    logic         s_ready [2];
    logic         d_valid [2];
    logic [W-1:0] d_data  [2];

    logic [W-1:0] rx    [2][64];
    int           rx_n  [2];
    logic [W-1:0] ex    [2][64];
    int           ex_n  [2];
    real          acc_t [2][64];

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    initial begin
        sclk = 0;
        forever #(TS/2) sclk = ~sclk;
    end
    initial begin
        dclk = 0;
        #1.3;
        forever #(TD/2) dclk = ~dclk;
    end

    hs_cdc_link #(.DATA_W(W), .PROTO(HS_TWO_PHASE)) u_dut (
        .src_clk(sclk), .src_rst(s_rst[0]), .src_valid(s_valid[0]),
        .src_data(s_data[0]), .src_ready(s_ready[0]),
        .dst_clk(dclk), .dst_rst(d_rst[0]),
        .dst_valid(d_valid[0]), .dst_data(d_data[0])
    );

    hs_cdc_link #(.DATA_W(W), .PROTO(HS_FOUR_PHASE)) u_dut_rz (
        .src_clk(sclk), .src_rst(s_rst[1]), .src_valid(s_valid[1]),
        .src_data(s_data[1]), .src_ready(s_ready[1]),
        .dst_clk(dclk), .dst_rst(d_rst[1]),
        .dst_valid(d_valid[1]), .dst_data(d_data[1])
    );

    always @(negedge dclk) begin
        for (int m = 0; m < 2; m++) begin
            if (!d_rst[m] && d_valid[m] && rx_n[m] < 64) begin
                rx[m][rx_n[m]] = d_data[m];
                rx_n[m]++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input int m, input logic [W-1:0] w);
        @(negedge sclk);
        s_valid[m] = 1'b1;
        s_data[m]  = w;
        while (!s_ready[m]) @(negedge sclk);
        @(posedge sclk);
        ex[m][ex_n[m]]    = w;
        acc_t[m][ex_n[m]] = $realtime;
        ex_n[m]++;
    endtask

    task automatic go_idle(input int m);
        @(negedge sclk);
        s_valid[m] = 1'b0;
    endtask

    task automatic run_mode(input int m);
        int  first;
        real lo, hi, dt;
        string tag;
        tag = (m == 0) ? "R6" : "R7";
        lo  = (m == 0) ? (2.0*TS + 2.0*TD) : (4.0*TS + 4.0*TD);
        hi  = (m == 0) ? (3.0*TS + 3.0*TD) : (6.0*TS + 6.0*TD);
        first = ex_n[m];
        // table walk, back to back
        for (int i = 0; i < NW; i++) send(m, WORDS[i]);
        go_idle(m);
        repeat (20) @(negedge sclk);
        for (int k = first + 1; k < ex_n[m]; k++) begin
            dt = acc_t[m][k] - acc_t[m][k-1];
            chk(dt >= lo, {tag, " min spacing"}, $rtoi(dt), $rtoi(lo));
            chk(dt <= hi, {tag, " max spacing"}, $rtoi(dt), $rtoi(hi));
        end
        chk(rx_n[m] == ex_n[m], "R4 word count", rx_n[m], ex_n[m]);
        for (int k = 0; k < ex_n[m]; k++)
            chk(rx[m][k] == ex[m][k], "R4 order/value", int'(rx[m][k]), int'(ex[m][k]));
        chk(d_data[m] == WORDS[NW-1], "R5 data held", int'(d_data[m]), int'(WORDS[NW-1]));
        repeat (10) @(negedge sclk);
        chk(d_data[m] == WORDS[NW-1], "R5 data held later", int'(d_data[m]), int'(WORDS[NW-1]));
        chk(d_valid[m] == 1'b0, "R4 no extra strobe", int'(d_valid[m]), 0);

        // busy offer must be ignored
        send(m, 16'h1234);
        @(negedge sclk);
        chk(s_ready[m] == 1'b0, "R3 ready low while busy", int'(s_ready[m]), 0);
        s_data[m] = 16'hDEAD;
        s_valid[m] = 1'b1;
        @(negedge sclk);
        s_valid[m] = 1'b0;
        repeat (20) @(negedge sclk);
        chk(rx_n[m] == ex_n[m], "R3 busy offer dropped", rx_n[m], ex_n[m]);
        chk(d_data[m] == 16'h1234, "R3 busy word absent", int'(d_data[m]), 16'h1234);
        chk(s_ready[m] == 1'b1, "R3 ready back", int'(s_ready[m]), 1);
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            s_rst[m] = 1'b1; d_rst[m] = 1'b1;
            s_valid[m] = 1'b0; s_data[m] = '0;
            rx_n[m] = 0; ex_n[m] = 0;
        end
        repeat (4) @(negedge sclk);
        for (int m = 0; m < 2; m++) begin
            chk(s_ready[m] == 1'b1, "R1 ready in reset", int'(s_ready[m]), 1);
            chk(d_valid[m] == 1'b0, "R1 valid in reset", int'(d_valid[m]), 0);
            chk(d_data[m] == '0, "R1 data in reset", int'(d_data[m]), 0);
        end
        // staggered release: destination first on one, source first on the other
        d_rst[0] = 1'b0;
        s_rst[1] = 1'b0;
        repeat (10) @(negedge sclk);
        s_rst[0] = 1'b0;
        d_rst[1] = 1'b0;
        repeat (10) @(negedge sclk);
        for (int m = 0; m < 2; m++) begin
            chk(rx_n[m] == 0, "R1 no spurious strobe", rx_n[m], 0);
            chk(s_ready[m] == 1'b1, "R1 ready after reset", int'(s_ready[m]), 1);
            chk(d_data[m] == '0, "R1 data after reset", int'(d_data[m]), 0);
        end

        run_mode(0);
        run_mode(1);

        // isolated word per mode after idle gap
        for (int m = 0; m < 2; m++) begin
            send(m, 16'hC0DE);
            go_idle(m);
            repeat (20) @(negedge sclk);
            chk(rx[m][rx_n[m]-1] == 16'hC0DE, "R4 isolated word", int'(rx[m][rx_n[m]-1]), 16'hC0DE);
            chk(rx_n[m] == ex_n[m], "R4 isolated count", rx_n[m], ex_n[m]);
        end

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule